// File: doc/BRIEF.md
# LWE Vector-Matrix MAC Engine

This block produces one ciphertext of a standard-lattice LWE encryption. It makes three passes of identical shape, one over each key matrix, in the fixed order A0, A1, P. Each pass computes a vector-by-matrix product between the error vector e1 and the matrix, one column at a time, on a single multiply-accumulate datapath. All arithmetic is modulo 2^Q_BITS, which is done by keeping only the low Q_BITS bits, so no reduction circuit is needed. A fresh Gaussian noise sample is added to every finished column. On the P pass, the encoded message bit is added as well: 0 or half the modulus.

The key matrices sit in an external memory. The engine reads them through a read port with one cycle of latency, driven by row, column and matrix counters. Gaussian samples arrive signed on a valid/ready stream and are sign-extended to Q_BITS. The error vector e1 lives in a two-bank store. The active bank feeds the current encryption while the idle bank collects new samples, so each encryption uses the vector gathered during the one before. Only the first encryption after reset waits for a full vector. The finished columns leave on a write port tagged with matrix code and column, and `done` marks the last one.

Top module: `lwe_mac_engine`

## Requirements
- R1: After reset, `busy`, `done`, `ct_we`, `key_rd_en` and `smp_ready` are all 0.
- R2: For matrix codes 0 (A0) and 1 (A1), each written column j equals (sum over i of e1[i]·M[i][j] + noise) mod 2^Q_BITS. Every sample is taken as two's complement and sign-extended to Q_BITS bits.
- R3: For matrix code 2 (P), the column value also includes 2^(Q_BITS-1) when `msg_bit` is 1. `msg_bit` is read for the column shown on `msg_col`.
- R4: An encryption writes exactly 3·N_COLS columns, in matrix order 0, 1, 2 and ascending column order within each matrix. `done` is a one-cycle pulse that coincides with the write of matrix 2, column N_COLS-1.
- R5: Key reads step the row fastest, then the column, then the matrix. `key_data` is taken one cycle after a cycle with `key_rd_en` high.
- R6: When the idle bank is already full and samples are always offered, `done` is seen exactly 3·N_COLS·N_ROWS+1 cycles after `busy` is first seen high.
- R7: While the samples a column needs are missing, key reads stop and the key address holds. No column is finished without its own noise sample, so results stay exact under a starved sample stream.
- R8: The sample stream is used in a fixed order. At start, any missing idle-bank entries are filled first, and then the banks exchange. In each column, the noise sample comes first, followed by one e1 entry while the idle bank is still incomplete. The first encryption after reset therefore takes N_ROWS samples before its first key read.
- R9: A `start` pulse seen while `busy` is high has no effect: the run still writes 3·N_COLS columns and pulses `done` once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin one encryption (honoured when idle) |
| busy | output | 1 | Encryption or initial fill in progress |
| done | output | 1 | One-cycle pulse with the final column write |
| key_rd_en | output | 1 | Key memory read enable |
| key_mat | output | 2 | Matrix code: 0 A0, 1 A1, 2 P |
| key_row | output | ROW_W | Key row address |
| key_col | output | COL_W | Key column address |
| key_data | input | Q_BITS | Key word, valid one cycle after the read |
| smp_valid | input | 1 | Gaussian sample offered |
| smp_ready | output | 1 | Engine accepts a sample this cycle |
| smp_data | input | S_BITS | Signed Gaussian sample |
| msg_col | output | COL_W | Column whose message bit is wanted |
| msg_bit | input | 1 | Message bit for `msg_col` |
| ct_we | output | 1 | Ciphertext write strobe |
| ct_mat | output | 2 | Matrix code of the written column |
| ct_col | output | COL_W | Column index of the written value |
| ct_data | output | Q_BITS | Ciphertext value mod 2^Q_BITS |

## Verification
The assertions take three things for granted about the environment. First, `key_data` holds its value in any cycle without a read. Second, `msg_bit` follows `msg_col` combinationally. Third, samples fit in S_BITS as two's complement. The bench meets all three: its key memory model only updates on an enabled read, it drives the message bit straight from a vector indexed by `msg_col`, and it draws samples from the range -45 to 45. Its reference model consumes the sample stream in the fixed order of R8. For that reason, starved runs only lengthen the schedule and never change which sample is used where.

// File: rtl/lwe_mac_pkg.sv
package lwe_mac_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_FILL = 2'd1,
    ST_RUN  = 2'd2
  } eng_state_t;

  // matrix codes seen on key_mat / ct_mat; pass order follows the code
  localparam logic [1:0] MAT_A0 = 2'd0;
  localparam logic [1:0] MAT_A1 = 2'd1;
  localparam logic [1:0] MAT_P  = 2'd2;

endpackage

// File: rtl/lwe_e1_pingpong.sv
module lwe_e1_pingpong #(
  parameter int DEPTH = 256,
  parameter int WIDTH = 12,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             swap,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [WIDTH-1:0] rd_data
);

  logic             act_bank;
  logic [WIDTH-1:0] mem [2*DEPTH];

  always_ff @(posedge clk) begin
    if (rst) act_bank <= 1'b0;
    else if (swap) act_bank <= ~act_bank;
  end

  // writes land in the idle bank, reads come from the active bank
  always_ff @(posedge clk) begin
    if (wr_en) mem[{~act_bank, wr_idx}] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rd_en) rd_data <= mem[{act_bank, rd_idx}];
  end

  // R8
  swap_no_read_chk: assert property (@(posedge clk) disable iff (rst)
    swap |-> !rd_en);

endmodule

// File: rtl/lwe_pass_seq.sv
module lwe_pass_seq
  import lwe_mac_pkg::*;
#(
  parameter int N_ROWS = 256,
  parameter int N_COLS = 128,
  localparam int ROW_W = (N_ROWS > 1) ? $clog2(N_ROWS) : 1,
  localparam int COL_W = (N_COLS > 1) ? $clog2(N_COLS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             launch,
  input  logic             advance,
  output logic             active,
  output logic [1:0]       mat,
  output logic [COL_W-1:0] col,
  output logic [ROW_W-1:0] row,
  output logic             row_first,
  output logic             row_last,
  output logic             all_last
);

  logic col_last;

  assign row_first = (row == '0);
  assign row_last  = (row == ROW_W'(N_ROWS - 1));
  assign col_last  = (col == COL_W'(N_COLS - 1));
  assign all_last  = (mat == MAT_P) && col_last;

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      mat    <= MAT_A0;
      col    <= '0;
      row    <= '0;
    end else if (launch) begin
      active <= 1'b1;
      mat    <= MAT_A0;
      col    <= '0;
      row    <= '0;
    end else if (advance) begin
      if (row_last) begin
        row <= '0;
        if (col_last) begin
          col <= '0;
          if (mat == MAT_P) active <= 1'b0;
          else mat <= mat + 2'd1;
        end else begin
          col <= col + 1'b1;
        end
      end else begin
        row <= row + 1'b1;
      end
    end
  end

  // R5
  row_step_chk: assert property (@(posedge clk) disable iff (rst)
    (advance && active && !row_last && !launch) |=> row == ROW_W'($past(row) + 1'b1));

endmodule

// File: rtl/lwe_mac_dp.sv
module lwe_mac_dp
  import lwe_mac_pkg::*;
#(
  parameter int Q_BITS = 12,
  parameter int COL_W  = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step,
  input  logic              first,
  input  logic              last,
  input  logic [1:0]        mat,
  input  logic [COL_W-1:0]  col,
  input  logic [Q_BITS-1:0] e1_val,
  input  logic [Q_BITS-1:0] key_val,
  input  logic [Q_BITS-1:0] noise,
  input  logic              msg_bit,
  output logic              ct_we,
  output logic [1:0]        ct_mat,
  output logic [COL_W-1:0]  ct_col,
  output logic [Q_BITS-1:0] ct_data
);

  localparam logic [Q_BITS-1:0] HALF_Q = {1'b1, {(Q_BITS-1){1'b0}}};

  logic [2*Q_BITS-1:0] prod_full;
  logic [Q_BITS-1:0]   prod, acc, acc_next, msg_add;

  // modulus is a power of two: keeping the low bits is the reduction
  assign prod_full = e1_val * key_val;
  assign prod      = prod_full[Q_BITS-1:0];
  assign acc_next  = (first ? '0 : acc) + prod;
  assign msg_add   = (mat == MAT_P && msg_bit) ? HALF_Q : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc     <= '0;
      ct_we   <= 1'b0;
      ct_mat  <= '0;
      ct_col  <= '0;
      ct_data <= '0;
    end else begin
      ct_we <= step && last;
      if (step) acc <= acc_next;
      if (step && last) begin
        ct_data <= acc_next + noise + msg_add;
        ct_mat  <= mat;
        ct_col  <= col;
      end
    end
  end

  // R4
  ct_mat_code_chk: assert property (@(posedge clk) disable iff (rst)
    ct_we |-> ct_mat != 2'd3);

endmodule

// File: rtl/lwe_mac_engine.sv
module lwe_mac_engine
  import lwe_mac_pkg::*;
#(
  parameter int N_ROWS = 256,
  parameter int N_COLS = 128,
  parameter int Q_BITS = 12,
  parameter int S_BITS = 7,
  localparam int ROW_W = (N_ROWS > 1) ? $clog2(N_ROWS) : 1,
  localparam int COL_W = (N_COLS > 1) ? $clog2(N_COLS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  output logic              busy,
  output logic              done,
  output logic              key_rd_en,
  output logic [1:0]        key_mat,
  output logic [ROW_W-1:0]  key_row,
  output logic [COL_W-1:0]  key_col,
  input  logic [Q_BITS-1:0] key_data,
  input  logic              smp_valid,
  output logic              smp_ready,
  input  logic [S_BITS-1:0] smp_data,
  output logic [COL_W-1:0]  msg_col,
  input  logic              msg_bit,
  output logic              ct_we,
  output logic [1:0]        ct_mat,
  output logic [COL_W-1:0]  ct_col,
  output logic [Q_BITS-1:0] ct_data
);

  localparam int FC_W = $clog2(N_ROWS + 1);

  eng_state_t        state;
  logic [FC_W-1:0]   fill_cnt;
  logic              fill_full, fill_used;
  logic              noise_have;
  logic [Q_BITS-1:0] noise_reg, smp_ext, e1_q;
  logic              accept, to_noise, to_fill, swap, launch;
  logic              col_ok, stall, step;
  logic              seq_active, seq_first, seq_last, seq_final;
  logic [1:0]        seq_mat;
  logic [COL_W-1:0]  seq_col;
  logic [ROW_W-1:0]  seq_row;
  logic              s1_valid, s1_first, s1_last, s1_final;
  logic [1:0]        s1_mat;
  logic [COL_W-1:0]  s1_col;

  assign smp_ext   = {{(Q_BITS-S_BITS){smp_data[S_BITS-1]}}, smp_data};
  assign fill_full = (fill_cnt == FC_W'(N_ROWS));

  // a column may close only with its noise and, while filling, its e1 entry
  assign col_ok = noise_have && (fill_used || fill_full);
  assign stall  = s1_valid && s1_last && !col_ok;
  assign step   = s1_valid && !stall;

  assign key_rd_en = seq_active && !stall;
  assign key_mat   = seq_mat;
  assign key_row   = seq_row;
  assign key_col   = seq_col;
  assign msg_col   = s1_col;
  assign busy      = (state != ST_IDLE);

  always_comb begin
    smp_ready = 1'b0;
    if (state == ST_FILL) smp_ready = 1'b1;
    else if (state == ST_RUN) smp_ready = !noise_have || (!fill_full && !fill_used);
  end

  assign accept   = smp_valid && smp_ready;
  assign to_noise = accept && (state == ST_RUN) && !noise_have;
  assign to_fill  = accept && ((state == ST_FILL) || ((state == ST_RUN) && noise_have));

  assign swap = ((state == ST_IDLE) && start && fill_full) ||
                ((state == ST_FILL) && to_fill && (fill_cnt == FC_W'(N_ROWS - 1)));
  assign launch = swap;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      fill_cnt   <= '0;
      fill_used  <= 1'b0;
      noise_have <= 1'b0;
      noise_reg  <= '0;
      done       <= 1'b0;
    end else begin
      done <= 1'b0;
      if (swap) fill_cnt <= '0;
      else if (to_fill) fill_cnt <= fill_cnt + 1'b1;
      if (to_noise) begin
        noise_have <= 1'b1;
        noise_reg  <= smp_ext;
      end
      if (to_fill && state == ST_RUN) fill_used <= 1'b1;
      case (state)
        ST_IDLE: begin
          fill_used <= 1'b0;
          if (start) state <= fill_full ? ST_RUN : ST_FILL;
        end
        ST_FILL: if (swap) state <= ST_RUN;
        ST_RUN: begin
          if (step && s1_last) begin
            noise_have <= 1'b0;
            fill_used  <= 1'b0;
            if (s1_final) begin
              state <= ST_IDLE;
              done  <= 1'b1;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // pipeline stage aligned with the memory outputs; frozen while stalled
  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s1_first <= 1'b0;
      s1_last  <= 1'b0;
      s1_final <= 1'b0;
      s1_mat   <= '0;
      s1_col   <= '0;
    end else if (!stall) begin
      s1_valid <= key_rd_en;
      if (key_rd_en) begin
        s1_first <= seq_first;
        s1_last  <= seq_last;
        s1_final <= seq_final;
        s1_mat   <= seq_mat;
        s1_col   <= seq_col;
      end
    end
  end

  lwe_pass_seq #(.N_ROWS(N_ROWS), .N_COLS(N_COLS)) u_seq (
    .clk(clk), .rst(rst), .launch(launch), .advance(key_rd_en),
    .active(seq_active), .mat(seq_mat), .col(seq_col), .row(seq_row),
    .row_first(seq_first), .row_last(seq_last), .all_last(seq_final)
  );

  lwe_e1_pingpong #(.DEPTH(N_ROWS), .WIDTH(Q_BITS)) u_e1 (
    .clk(clk), .rst(rst), .swap(swap),
    .wr_en(to_fill), .wr_idx(fill_cnt[ROW_W-1:0]), .wr_data(smp_ext),
    .rd_en(key_rd_en), .rd_idx(seq_row), .rd_data(e1_q)
  );

  lwe_mac_dp #(.Q_BITS(Q_BITS), .COL_W(COL_W)) u_dp (
    .clk(clk), .rst(rst), .step(step), .first(s1_first), .last(s1_last),
    .mat(s1_mat), .col(s1_col), .e1_val(e1_q), .key_val(key_data),
    .noise(noise_reg), .msg_bit(msg_bit),
    .ct_we(ct_we), .ct_mat(ct_mat), .ct_col(ct_col), .ct_data(ct_data)
  );

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    stall |=> $stable(key_row) && $stable(key_col) && $stable(key_mat));

  // R4
  done_last_write_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> ct_we && ct_mat == MAT_P && ct_col == COL_W'(N_COLS - 1));

  // R4
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R8
  fill_after_noise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(fill_used) |-> noise_have);

  // R8
  fill_bound_chk: assert property (@(posedge clk) disable iff (rst)
    fill_cnt <= FC_W'(N_ROWS));

endmodule

// File: tb/lwe_mac_engine_bench.sv
`timescale 1ns/1ps
module lwe_mac_engine_bench;

  localparam int N_ROWS = 8;
  localparam int N_COLS = 4;
  localparam int Q_BITS = 12;
  localparam int S_BITS = 7;
  localparam int ROW_W  = $clog2(N_ROWS);
  localparam int COL_W  = $clog2(N_COLS);
  localparam int N_CT   = 3 * N_COLS;
  localparam int N_KEY  = 3 * N_ROWS * N_COLS;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic busy, done, key_rd_en, smp_valid, smp_ready, msg_bit, ct_we;
  logic [1:0] key_mat, ct_mat;
  logic [ROW_W-1:0] key_row;
  logic [COL_W-1:0] key_col, msg_col, ct_col;
  logic [Q_BITS-1:0] key_data, ct_data;
  logic [S_BITS-1:0] smp_data;

  always #2.5 clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  logic [Q_BITS-1:0] key_mem [N_KEY];
  int smp_arr [2048];
  int sp, mp;
  logic gap_mode = 1'b0;
  logic [2:0] gcnt;
  logic [N_COLS-1:0] msg_vec;
  int m_cur [N_ROWS];
  int m_idle [N_ROWS];
  int m_fill = 0;
  int exp_ct [N_CT];
  int got_ct [N_CT];
  int wr_cnt, done_cnt, ord_err, rd_idx, rd_err;

  lwe_mac_engine #(.N_ROWS(N_ROWS), .N_COLS(N_COLS), .Q_BITS(Q_BITS), .S_BITS(S_BITS)) u_lwe_mac_engine (
    .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
    .key_rd_en(key_rd_en), .key_mat(key_mat), .key_row(key_row), .key_col(key_col),
    .key_data(key_data), .smp_valid(smp_valid), .smp_ready(smp_ready), .smp_data(smp_data),
    .msg_col(msg_col), .msg_bit(msg_bit),
    .ct_we(ct_we), .ct_mat(ct_mat), .ct_col(ct_col), .ct_data(ct_data)
  );

  // environment models: key memory with one-cycle read, sample source, message
  always @(posedge clk)
    if (key_rd_en) key_data <= key_mem[(int'(key_mat) * N_ROWS + int'(key_row)) * N_COLS + int'(key_col)];

  always @(posedge clk) begin
    if (rst) begin
      sp   <= 0;
      gcnt <= '0;
    end else begin
      gcnt <= gcnt + 3'd1;
      if (smp_valid && smp_ready) sp <= sp + 1;
    end
  end

  assign smp_valid = !rst && (!gap_mode || gcnt == 3'd0);
  assign smp_data  = S_BITS'(smp_arr[sp]);
  assign msg_bit   = msg_vec[msg_col];

  // port monitor, sampled away from the rising edge
  always @(negedge clk) begin
    if (!rst) begin
      if (ct_we) begin
        got_ct[int'(ct_mat) * N_COLS + int'(ct_col)] = int'(ct_data);
        if (int'(ct_mat) != wr_cnt / N_COLS || int'(ct_col) != wr_cnt % N_COLS) ord_err++;
        wr_cnt++;
      end
      if (done) done_cnt++;
      if (key_rd_en) begin
        if (int'(key_row) != rd_idx % N_ROWS ||
            int'(key_col) != (rd_idx / N_ROWS) % N_COLS ||
            int'(key_mat) != rd_idx / (N_ROWS * N_COLS)) rd_err++;
        rd_idx++;
      end
    end
  end

  task automatic chk(input string req, input int act, input int expv);
    n_chk++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
  endtask

  task automatic set_keys(input int mode);
    for (int k = 0; k < N_KEY; k++)
      key_mem[k] = (mode == 1) ? 12'hFFF : Q_BITS'($urandom_range(4095));
  endtask

  task automatic set_samples(input int mode);
    for (int k = mp; k < mp + 128; k++)
      case (mode)
        1:       smp_arr[k] = 45;
        2:       smp_arr[k] = -45;
        default: smp_arr[k] = int'($urandom_range(90)) - 45;
      endcase
  endtask

  // reference: stream order per R8, arithmetic per R2/R3
  task automatic model_enc();
    while (m_fill < N_ROWS) begin
      m_idle[m_fill] = smp_arr[mp];
      mp++;
      m_fill++;
    end
    for (int i = 0; i < N_ROWS; i++) m_cur[i] = m_idle[i];
    m_fill = 0;
    for (int k = 0; k < 3; k++) begin
      for (int c = 0; c < N_COLS; c++) begin
        int s;
        s = smp_arr[mp];
        mp++;
        if (m_fill < N_ROWS) begin
          m_idle[m_fill] = smp_arr[mp];
          mp++;
          m_fill++;
        end
        for (int i = 0; i < N_ROWS; i++)
          s += m_cur[i] * int'(key_mem[(k * N_ROWS + i) * N_COLS + c]);
        if (k == 2 && msg_vec[c]) s += 2048;
        exp_ct[k * N_COLS + c] = s & 4095;
      end
    end
  endtask

  task automatic run_enc(input logic gap, input int restart_at, output int cycles);
    wr_cnt = 0; done_cnt = 0; ord_err = 0; rd_idx = 0; rd_err = 0;
    model_enc();
    gap_mode = gap;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    cycles = 0;
    chk("R9 busy after start", int'(busy), 1);
    while (!done && cycles < 20000) begin
      @(negedge clk);
      cycles++;
      if (cycles == restart_at) start = 1'b1;
      else start = 1'b0;
    end
    start = 1'b0;
    repeat (30) @(negedge clk);
    gap_mode = 1'b0;
  endtask

  task automatic check_results(input string tag);
    for (int k = 0; k < N_CT; k++)
      chk((k < 2 * N_COLS) ? {"R2 ", tag} : {"R3 ", tag}, got_ct[k], exp_ct[k]);
    chk({"R4 write count ", tag}, wr_cnt, N_CT);
    chk({"R4 done count ", tag}, done_cnt, 1);
    chk({"R4 write order ", tag}, ord_err, 0);
    chk({"R5 read order ", tag}, rd_err, 0);
    chk({"R5 read count ", tag}, rd_idx, N_KEY);
    chk({"R8 samples used ", tag}, sp, mp);
    chk({"R9 idle after ", tag}, int'(busy), 0);
  endtask

  task automatic test_reset();
    chk("R1 busy", int'(busy), 0);
    chk("R1 done", int'(done), 0);
    chk("R1 ct_we", int'(ct_we), 0);
    chk("R1 key_rd_en", int'(key_rd_en), 0);
    chk("R1 smp_ready", int'(smp_ready), 0);
  endtask

  task automatic test_first_encryption();
    int cyc;
    set_keys(0); set_samples(0); msg_vec = 4'b1010;
    run_enc(1'b0, -1, cyc);
    check_results("first");
    // R8: initial fill of N_ROWS samples precedes the reads
    chk("R8 first run length", cyc, N_ROWS + N_KEY + 1);
  endtask

  task automatic test_back_to_back();
    int cyc;
    set_keys(0); set_samples(0); msg_vec = 4'b0110;
    run_enc(1'b0, -1, cyc);
    check_results("second");
    chk("R6 cycles busy to done", cyc, N_KEY + 1);
  endtask

  task automatic test_starved_samples();
    int cyc;
    set_keys(0); set_samples(0); msg_vec = 4'b1101;
    run_enc(1'b1, -1, cyc);
    check_results("starved");
    chk("R7 stalls lengthen run", int'(cyc > N_KEY + 1), 1);
  endtask

  task automatic test_wraparound();
    int cyc;
    set_keys(1); set_samples(1); msg_vec = 4'b1111;
    run_enc(1'b0, -1, cyc);
    check_results("wrap high");
    set_samples(2); msg_vec = 4'b1111;
    run_enc(1'b0, -1, cyc);
    check_results("wrap low");
  endtask

  task automatic test_start_while_busy();
    int cyc;
    set_keys(0); set_samples(0); msg_vec = 4'b0011;
    run_enc(1'b0, 20, cyc);
    check_results("restart ignored");
    chk("R9 single run length", cyc, N_KEY + 1);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    test_reset();
    test_first_encryption();
    test_back_to_back();
    test_starved_samples();
    test_wraparound();
    test_start_while_busy();
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
    $finish;
  end

endmodule